// File: doc/BRIEF.md
# Task Group Completion Sequencer

This block sequences one run of a group of child tasks. A start request is carried through a register chain whose depth matches the control pipeline that fans out to the children. When the delayed start arrives, the sequencer leaves its idle state and waits until every child reports that it has finished, with all of those flags high on the same clock edge. It then raises a one-cycle ready pulse. The same pulse, delayed by the same chain depth, becomes the done output and the completion broadcast to the children.

After completion the sequencer does not return to idle at once. It first counts down for as many cycles as the pipeline is deep. This lets the completion broadcast reach every child before a new start can be accepted. The delayed start and the delayed completion are both exported, so that a parent can distribute them.

The four states are IDLE (2'b00, waiting for the delayed start), BUSY (2'b01, waiting for every child flag), DONE (2'b10, one cycle, loads the countdown) and DRAIN (2'b11, counts down to zero). The transitions are:
- IDLE to BUSY on the delayed start.
- BUSY to DONE when all child flags are high. With zero children this happens on the next edge.
- DONE to DRAIN, or DONE straight to IDLE when the pipeline depth is zero.
- DRAIN to IDLE when the countdown reads zero.

Top module: `task_group_sequencer`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the sequencer enters IDLE and clears both register chains. After that edge, `idle`=1 and `ready`, `done`, `start_out` and `done_out` are all 0.
- R2: `start_out` equals `start` delayed by exactly LEVEL clock edges. With LEVEL=0 it is `start` itself.
- R3: In IDLE, a high `start_out` at an edge moves the sequencer to BUSY, and `idle` is low after that edge. While the sequencer is in BUSY, DONE or DRAIN, `start_out` is ignored.
- R4: In BUSY, the sequencer moves to DONE only at an edge where every bit of `task_done` is high. A vector that is only partly high keeps it in BUSY. With NUM_TASKS=0 it leaves BUSY after one cycle.
- R5: `ready` is high exactly while the state is DONE. Each completion gives a single-cycle pulse.
- R6: `done` and `done_out` equal `ready` delayed by exactly LEVEL clock edges.
- R7: For LEVEL>0, DONE is followed by LEVEL cycles of DRAIN, counting down from LEVEL-1 to 0, and then IDLE. If `ready` is high in cycle t, `idle` rises in cycle t+LEVEL+1. For LEVEL=0, DONE returns straight to IDLE.
- R8: `idle` is high in IDLE and low in BUSY, DONE and DRAIN.
- R9: If `start` is held high, the sequencer leaves IDLE again one cycle after it returned there. `idle` is high for exactly one cycle between runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request entering the start chain |
| task_done | input | max(NUM_TASKS,1) | One finished flag per child task |
| idle | output | 1 | High while the state is IDLE |
| ready | output | 1 | High while the state is DONE (stage 0 of the completion chain) |
| done | output | 1 | Last stage of the completion chain |
| start_out | output | 1 | Last stage of the start chain, broadcast to the children |
| done_out | output | 1 | Last stage of the completion chain, broadcast to the children |

## Verification
The bench drives `task_done` patterns in which different subsets of bits are high on different edges. A design that ORed the flags, or that remembered bits across edges, would leave BUSY early. It counts the cycles from `ready` to `done` and from `ready` to the return of `idle`, which catches an off-by-one in the countdown load or in the drain exit. A wrong count would show up as a drain that is one cycle short or one cycle long. It also pulses `start` while a run is in flight, holds `start` high across consecutive runs, and asserts reset in the middle of a run. A design that latched a start while busy would start a spurious run. A design that did not clear its chains on reset would report a stale completion.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BUSY  = 2'b01,
        ST_DONE  = 2'b10,
        ST_DRAIN = 2'b11
    } tgs_state_e;
endpackage

// File: rtl/tgs_delay_line.sv
module tgs_delay_line #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [DEPTH-1:0] stage;
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                if (i == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (rst) stage[0] <= 1'b0;
                        else     stage[0] <= din;
                    end
                    assert_first_stage_R2: assert property (@(posedge clk) disable iff (rst)
                        1'b1 |=> stage[0] == $past(din));
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (rst) stage[i] <= 1'b0;
                        else     stage[i] <= stage[i-1];
                    end
                    assert_shift_stage_R2: assert property (@(posedge clk) disable iff (rst)
                        1'b1 |=> stage[i] == $past(stage[i-1]));
                end
            end
            assign dout = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/tgs_drain_counter.sv
module tgs_drain_counter #(
    parameter int LEVEL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int CW    = (LEVEL <= 1) ? 1 : $clog2(LEVEL);
    localparam int LOADV = (LEVEL > 0) ? LEVEL - 1 : 0;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= CW'(LOADV);
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    assert_load_value_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == CW'(LOADV));
    assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/tgs_fsm.sv
module tgs_fsm
    import tgs_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int LEVEL     = 3,
    localparam int DW       = (NUM_TASKS > 0) ? NUM_TASKS : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] task_done,
    input  logic          cnt_zero,
    output logic          in_idle,
    output logic          in_done,
    output logic          cnt_load,
    output logic          cnt_dec
);
    tgs_state_e state, state_nx;
    logic       all_done;

    generate
        if (NUM_TASKS == 0) begin : g_none
            assign all_done = 1'b1;
        end else begin : g_some
            assign all_done = &task_done;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go)       state_nx = ST_BUSY;
            ST_BUSY:  if (all_done) state_nx = ST_DONE;
            ST_DONE:  state_nx = (LEVEL > 0) ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (cnt_zero) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_idle  = (state == ST_IDLE);
        in_done  = (state == ST_DONE);
        cnt_load = (state == ST_DONE);
        cnt_dec  = (state == ST_DRAIN);
    end

    assert_idle_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && go) |=> state == ST_BUSY);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !go) |=> state == ST_IDLE);
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && !all_done) |=> state == ST_BUSY);
    assert_busy_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && all_done) |=> state == ST_DONE);
    generate
        if (LEVEL > 0) begin : g_drain_chk
            assert_done_to_drain_R7: assert property (@(posedge clk) disable iff (rst)
                state == ST_DONE |=> state == ST_DRAIN);
        end else begin : g_nodrain_chk
            assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
                state == ST_DONE |=> state == ST_IDLE);
        end
    endgenerate
endmodule

// File: rtl/task_group_sequencer.sv
module task_group_sequencer #(
    parameter int NUM_TASKS = 4,
    parameter int LEVEL     = 3,
    localparam int DW       = (NUM_TASKS > 0) ? NUM_TASKS : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] task_done,
    output logic          idle,
    output logic          ready,
    output logic          done,
    output logic          start_out,
    output logic          done_out
);
    logic go_q;
    logic in_done;
    logic cnt_load, cnt_dec, cnt_zero;
    logic done_q;

    tgs_delay_line #(.DEPTH(LEVEL)) u_start_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (start),
        .dout (go_q)
    );

    tgs_fsm #(.NUM_TASKS(NUM_TASKS), .LEVEL(LEVEL)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go_q),
        .task_done (task_done),
        .cnt_zero  (cnt_zero),
        .in_idle   (idle),
        .in_done   (in_done),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec)
    );

    tgs_drain_counter #(.LEVEL(LEVEL)) u_drain (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .dec  (cnt_dec),
        .zero (cnt_zero)
    );

    tgs_delay_line #(.DEPTH(LEVEL)) u_done_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (in_done),
        .dout (done_q)
    );

    assign ready     = in_done;
    assign done      = done_q;
    assign done_out  = done_q;
    assign start_out = go_q;

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    assert_ready_not_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !(ready && idle));
endmodule

// File: tb/task_group_sequencer_tb.sv
module task_group_sequencer_tb;
    localparam int  NT     = 4;
    localparam int  LV     = 3;
    localparam time PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [NT-1:0] task_done;
    logic          idle, ready, done, start_out, done_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit armed  = 0;

    // behavioural reference model
    int m_state = 0;   // 0 idle, 1 busy, 2 done, 3 drain
    int m_cnt   = 0;
    bit sq[$];
    bit dq[$];

    task_group_sequencer #(.NUM_TASKS(NT), .LEVEL(LV)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .task_done (task_done),
        .idle      (idle),
        .ready     (ready),
        .done      (done),
        .start_out (start_out),
        .done_out  (done_out)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit go;
        int ns;
        cycles++;
        if (rst) begin
            m_state = 0; m_cnt = 0;
            sq = {}; dq = {};
            for (int i = 0; i < LV; i++) begin sq.push_back(1'b0); dq.push_back(1'b0); end
            armed = 1;
        end else begin
            go = sq[LV-1];
            ns = m_state;
            case (m_state)
                0: if (go) ns = 1;
                1: if (task_done == {NT{1'b1}}) ns = 2;
                2: begin ns = 3; m_cnt = LV - 1; end
                default: if (m_cnt == 0) ns = 0; else m_cnt--;
            endcase
            dq.push_front(m_state == 2); void'(dq.pop_back());
            sq.push_front(start);        void'(sq.pop_back());
            m_state = ns;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk("R8", idle,      m_state == 0, "idle");
            chk("R5", ready,     m_state == 2, "ready");
            chk("R6", done,      dq[LV-1],     "done");
            chk("R6", done_out,  dq[LV-1],     "done_out");
            chk("R2", start_out, sq[LV-1],     "start_out");
        end
    end

    task automatic step();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    bit tr_idle[16];
    bit tr_done[16];

    task automatic measure();
        int t = 0;
        while (!ready && t < 60) begin step(); t++; end
        chk("R5", ready, 1'b1, "ready reached");
        for (int k = 0; k < 16; k++) begin
            tr_idle[k] = idle;
            tr_done[k] = done;
            if (k < 15) step();
        end
        chk("R5", tr_done[0] | 1'b0, 1'b0, "done not same cycle as ready");
        chk("R6", tr_done[LV], 1'b1, "done exactly LEVEL after ready");
        chk("R6", tr_done[LV-1], 1'b0, "done not early");
        chk("R7", tr_idle[LV], 1'b0, "still draining at LEVEL");
        chk("R7", tr_idle[LV+1], 1'b1, "idle at LEVEL+1");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; task_done = '0;
        step(); step(); step();
        chk("R1", idle, 1'b1, "reset idle");
        chk("R1", ready | done | start_out | done_out, 1'b0, "reset outputs low");
        rst = 1'b0;

        // R4: partial vectors keep BUSY
        task_done = 4'b0101;
        start = 1'b1; step(); start = 1'b0;
        for (int i = 0; i < LV + 3; i++) step();
        chk("R3", idle, 1'b0, "left idle after delayed start");
        chk("R4", ready, 1'b0, "partial 0101 stays busy");
        task_done = 4'b1010; step(); step();
        chk("R4", ready, 1'b0, "partial 1010 stays busy");
        task_done = 4'b1111;
        measure();
        task_done = 4'b0000;

        // R3: start pulse during a run is ignored
        start = 1'b1; step(); start = 1'b0;
        for (int i = 0; i < LV + 2; i++) step();
        start = 1'b1; step(); start = 1'b0;
        task_done = 4'b1111;
        measure();
        for (int i = 0; i < 12; i++) step();
        chk("R3", idle, 1'b1, "no relaunch from start seen while busy");

        // R9: start held high relaunches after one idle cycle
        start = 1'b1;
        measure();
        chk("R9", tr_idle[LV+2], 1'b0, "relaunch one cycle after idle");
        start = 1'b0;
        for (int i = 0; i < 20; i++) step();

        // R1: reset in mid-run
        task_done = 4'b0011;
        start = 1'b1; step(); start = 1'b0;
        for (int i = 0; i < LV + 2; i++) step();
        task_done = 4'b1111; step();
        rst = 1'b1; step();
        chk("R1", idle, 1'b1, "mid-run reset idle");
        chk("R1", ready | done | done_out, 1'b0, "mid-run reset clears chain");
        rst = 1'b0;
        for (int i = 0; i < 10; i++) step();
        chk("R1", idle, 1'b1, "stays idle after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule